// File: doc/BRIEF.md
# Sized Shift and Rotate Unit with Condition Codes

This block executes arithmetic shifts and plain rotates on an operand held in a 32-bit register, treating it as a byte, a word or a long. After a start strobe it captures the operand, the count, the size, the direction and the operation, then moves the operand one bit position per clock until the count is spent. A final cycle forms the result and the five condition-code bits: extend, negative, zero, overflow and carry. A single-cycle done pulse accompanies them.

The execution stage of a processor core drives it with the operand and the incoming condition codes. It waits for done, then writes back the result and the new codes. Register bits above the selected size pass through untouched, so the same path serves all three sizes.

Top module: `shrot_unit`

## Requirements
- R1: The size code selects the active width: 00 byte (bits 7:0, sign bit 7), 01 word (bits 15:0, sign bit 15), 10 and 11 long (bits 31:0, sign bit 31).
- R2: Only the low 6 bits of the count input are used. One bit step happens per clock after the start edge, and done is high in the cycle after the (count+1)-th rising edge that follows the edge capturing start.
- R3: A left rotate (rotate=1, left=1) moves each bit up one place per step and copies the sized sign bit into bit 0. The last bit moved out becomes carry.
- R4: A right rotate (rotate=1, left=0) moves each bit down one place per step and copies bit 0 into the sized sign bit. The last bit moved out becomes carry.
- R5: Condition codes are laid out as bit 4 extend, bit 3 negative, bit 2 zero, bit 1 overflow, bit 0 carry. For a rotate, negative and zero come from the sized result, overflow is 0, and extend equals cc_in bit 4.
- R6: An arithmetic right shift (rotate=0, left=0) replicates the sign bit. Carry is the last bit moved out of bit 0, extend equals carry, and overflow is 0.
- R7: An arithmetic left shift (rotate=0, left=1) fills bit 0 with zero. Carry is the last sign bit moved out, extend equals carry, and overflow is set if the sign bit changed at any step.
- R8: A count of zero returns the operand unchanged, with carry 0 and overflow 0. Extend equals cc_in bit 4, and negative and zero come from the sized operand.
- R9: For every operation, result bits above the selected size equal the operand's bits.
- R10: A start strobe while an operation is in progress is ignored. The result is the one for the first operand.
- R11: After reset, result is 0, cc_out is 0 and done is 0.
- R12: done is high for exactly one cycle, and result and cc_out hold their values until the next done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation when idle |
| operand | input | DATA_W | 32-bit register value to shift or rotate |
| count | input | CNT_IN_W | Step count, taken modulo 64 |
| size | input | 2 | Operand size code |
| left | input | 1 | 1 = toward the sign bit, 0 = toward bit 0 |
| rotate | input | 1 | 1 = rotate, 0 = arithmetic shift |
| cc_in | input | 5 | Incoming condition codes; bit 4 supplies the kept extend |
| result | output | DATA_W | Final register value |
| cc_out | output | 5 | New condition codes |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its default parameters: a 32-bit register, an 8-bit count input and 6 significant count bits. With these values every size code, both operations and both directions can be swept against eight operand patterns that fill all 32 bits. The counts include 0, values on either side of 8, 16 and 32, 63, and values of 64 and above that must wrap. This covers rotation by whole multiples of the width, shifts that push every bit out, overflow on sign changes deep inside a long shift, and preservation of the upper bits. Exact latency is measured for every count.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_LALT = 2'b11
    } size_e;

    // bit 4 extend, 3 negative, 2 zero, 1 overflow, 0 carry
    typedef struct packed {
        logic x;
        logic n;
        logic z;
        logic v;
        logic c;
    } ccode_t;

    localparam int NUM_SIZES = 3;

    function automatic logic [1:0] size_lane(input logic [1:0] code);
        case (code)
            SZ_BYTE: return 2'd0;
            SZ_WORD: return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/shrot_step.sv
module shrot_step
    import shrot_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] val,
    input  logic [1:0]        size,
    input  logic              left,
    input  logic              rotate,
    output logic [DATA_W-1:0] nxt,
    output logic              out_bit,
    output logic              sign_flip
);
    localparam int BASE_W = DATA_W / 4;

    logic [DATA_W-1:0]    cand_val [NUM_SIZES];
    logic [NUM_SIZES-1:0] cand_out;
    logic [NUM_SIZES-1:0] cand_flip;
    logic [1:0]           sel;

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_lane
        localparam int W = BASE_W << g;
        logic [W-1:0]      lane;
        logic [W-1:0]      moved;
        logic [DATA_W-1:0] keep_mask;

        assign lane      = val[W-1:0];
        assign moved     = left ? {lane[W-2:0], rotate & lane[W-1]}
                                : {(rotate ? lane[0] : lane[W-1]), lane[W-1:1]};
        assign keep_mask = ~({DATA_W{1'b1}} >> (DATA_W - W));
        assign cand_val[g]  = (val & keep_mask) | DATA_W'(moved);
        assign cand_out[g]  = left ? lane[W-1] : lane[0];
        assign cand_flip[g] = moved[W-1] ^ lane[W-1];
    end

    assign sel       = size_lane(size);
    assign nxt       = cand_val[sel];
    assign out_bit   = cand_out[sel];
    assign sign_flip = cand_flip[sel];

    // R9: a byte step never disturbs bits above the byte lane
    always_comb begin
        if (sel == 2'd0)
            assert_byte_upper_kept_R9: assert (nxt[DATA_W-1:BASE_W] == val[DATA_W-1:BASE_W]);
    end

endmodule

// File: rtl/shrot_flags.sv
module shrot_flags
    import shrot_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] val,
    input  logic [1:0]        size,
    output logic              neg,
    output logic              zero
);
    localparam int BASE_W = DATA_W / 4;

    logic [NUM_SIZES-1:0] cand_neg;
    logic [NUM_SIZES-1:0] cand_zero;
    logic [1:0]           sel;

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_lane
        localparam int W = BASE_W << g;
        assign cand_neg[g]  = val[W-1];
        assign cand_zero[g] = (val[W-1:0] == '0);
    end

    assign sel  = size_lane(size);
    assign neg  = cand_neg[sel];
    assign zero = cand_zero[sel];

    // R5: a sized value cannot be both zero and negative
    always_comb begin
        assert_flag_excl_R5: assert (!(neg && zero));
    end

endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
    import shrot_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int CNT_IN_W = 8,
    parameter int CNT_W    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] operand,
    input  logic [CNT_IN_W-1:0] count,
    input  logic [1:0]        size,
    input  logic              left,
    input  logic              rotate,
    input  logic [4:0]        cc_in,
    output logic [DATA_W-1:0] result,
    output logic [4:0]        cc_out,
    output logic              done
);
    typedef struct packed {
        logic              busy;
        logic              done;
        logic [CNT_W-1:0]  remain;
        logic [DATA_W-1:0] work;
        logic [1:0]        sz;
        logic              left;
        logic              rot;
        logic              x_in;
        logic              carry;
        logic              ovf;
        logic              stepped;
        logic [DATA_W-1:0] result;
        ccode_t            cc;
    } state_t;

    state_t st_d, st_q;

    logic [DATA_W-1:0] step_nxt_d;
    logic              step_out_d;
    logic              step_flip_d;
    logic              neg_d;
    logic              zero_d;

    shrot_step #(.DATA_W(DATA_W)) u_step (
        .val       (st_q.work),
        .size      (st_q.sz),
        .left      (st_q.left),
        .rotate    (st_q.rot),
        .nxt       (step_nxt_d),
        .out_bit   (step_out_d),
        .sign_flip (step_flip_d)
    );

    shrot_flags #(.DATA_W(DATA_W)) u_flags (
        .val  (st_q.work),
        .size (st_q.sz),
        .neg  (neg_d),
        .zero (zero_d)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy    = 1'b1;
                st_d.remain  = count[CNT_W-1:0];
                st_d.work    = operand;
                st_d.sz      = size;
                st_d.left    = left;
                st_d.rot     = rotate;
                st_d.x_in    = cc_in[4];
                st_d.carry   = 1'b0;
                st_d.ovf     = 1'b0;
                st_d.stepped = 1'b0;
            end
        end else if (st_q.remain != '0) begin
            st_d.work    = step_nxt_d;
            st_d.carry   = step_out_d;
            st_d.ovf     = st_q.ovf | step_flip_d;
            st_d.stepped = 1'b1;
            st_d.remain  = st_q.remain - 1'b1;
        end else begin
            st_d.busy   = 1'b0;
            st_d.done   = 1'b1;
            st_d.result = st_q.work;
            st_d.cc.x   = (st_q.rot || !st_q.stepped) ? st_q.x_in : st_q.carry;
            st_d.cc.n   = neg_d;
            st_d.cc.z   = zero_d;
            st_d.cc.v   = !st_q.rot && st_q.ovf;
            st_d.cc.c   = st_q.carry;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result = st_q.result;
    assign cc_out = st_q.cc;
    assign done   = st_q.done;

    assert_step_countdown_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.remain != '0) |=> (st_q.remain == $past(st_q.remain) - 1'b1));

    assert_done_after_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(st_q.busy));

    assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.remain != '0) |=>
            ($stable(st_q.sz) && $stable(st_q.left) && $stable(st_q.rot)));

    assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_output_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(result) && $stable(cc_out)));

endmodule

// File: tb/sim_shrot_unit.sv
module sim_shrot_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] operand = '0;
    logic [7:0]  count = '0;
    logic [1:0]  size = '0;
    logic        left = 1'b0;
    logic        rotate = 1'b0;
    logic [4:0]  cc_in = '0;
    logic [31:0] result;
    logic [4:0]  cc_out;
    logic        done;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    shrot_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .operand(operand),
        .count(count), .size(size), .left(left), .rotate(rotate),
        .cc_in(cc_in), .result(result), .cc_out(cc_out), .done(done)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic void model(input logic [31:0] v, input logic [1:0] sz,
                                  input logic rot, input logic lf, input logic [7:0] cnt,
                                  input logic xin, output logic [31:0] res, output logic [4:0] cc);
        int w, n, k;
        logic [63:0] mask, lane, r, se, top;
        logic c, x, ov;
        w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        n = int'(cnt[5:0]);
        mask = (64'd1 << w) - 64'd1;
        lane = {32'd0, v} & mask;
        c = 1'b0; ov = 1'b0; x = xin; r = lane;
        if (rot) begin
            k = n % w;
            if (k != 0) begin
                if (lf) r = ((lane << k) | (lane >> (w - k))) & mask;
                else    r = ((lane >> k) | (lane << (w - k))) & mask;
            end
            if (n != 0) c = lf ? r[0] : r[w-1];
        end else if (!lf) begin
            se = lane[w-1] ? (lane | ~mask) : lane;
            r = 64'($signed(se) >>> n) & mask;
            if (n != 0) begin c = se[n-1]; x = c; end
        end else begin
            r = (lane << n) & mask;
            if (n != 0) begin
                c = (n <= w) ? lane[w-n] : 1'b0;
                x = c;
                if (n >= w) ov = (lane != 64'd0);
                else begin
                    top = lane >> (w - 1 - n);
                    ov = !(top == 64'd0 || top == ((64'd1 << (n + 1)) - 64'd1));
                end
            end
        end
        res = (v & ~mask[31:0]) | r[31:0];
        cc = {x, r[w-1], (r == 64'd0), ov, c};
    endfunction

    // drive one operation; returns edges from capture to done
    task automatic run_op(input logic [31:0] v, input logic [1:0] sz, input logic rot,
                          input logic lf, input logic [7:0] cnt, input logic xin, output int lat);
        @(negedge clk);
        operand = v; size = sz; rotate = rot; left = lf; count = cnt;
        cc_in = {xin, 4'b0101};
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] pats [8];
        logic [7:0]  cnts [17];
        logic [31:0] er;
        logic [4:0]  ec;
        logic [31:0] held_r;
        int lat;
        pats = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0001, 32'hA5C3_3C81,
                 32'h1234_5678, 32'h0000_0080, 32'h00FF_7F01, 32'hDEAD_8000};
        cnts = '{8'd0, 8'd1, 8'd2, 8'd3, 8'd7, 8'd8, 8'd9, 8'd15, 8'd16,
                 8'd17, 8'd31, 8'd32, 8'd33, 8'd63, 8'd64, 8'd65, 8'd129};

        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 result", result, 32'd0);
        chk("R11 cc", 32'(cc_out), 32'd0);
        chk("R11 done", 32'(done), 32'd0);
        rst_n = 1'b1;

        // directed cases, byte size per R1
        run_op(32'h0000_0080, 2'd0, 1'b1, 1'b1, 8'd1, 1'b0, lat);
        chk("R3 R1 rol byte", result, 32'h0000_0001);
        chk("R5 rol cc", 32'(cc_out), 32'h01);
        run_op(32'h0000_0001, 2'd0, 1'b1, 1'b0, 8'd1, 1'b0, lat);
        chk("R4 R1 ror byte", result, 32'h0000_0080);
        chk("R5 ror cc", 32'(cc_out), 32'h09);
        run_op(32'h0000_0081, 2'd0, 1'b0, 1'b0, 8'd1, 1'b0, lat);
        chk("R6 asr byte", result, 32'h0000_00C0);
        chk("R6 asr cc", 32'(cc_out), 32'h19);
        run_op(32'h0000_0001, 2'd0, 1'b0, 1'b1, 8'd1, 1'b0, lat);
        chk("R7 asl byte", result, 32'h0000_0002);
        chk("R7 asl cc", 32'(cc_out), 32'h00);

        // R12 pulse width and hold
        held_r = result;
        @(negedge clk);
        chk("R12 done drops", 32'(done), 32'd0);
        repeat (3) @(negedge clk);
        chk("R12 result held", result, held_r);

        // R10 start during busy ignored
        @(negedge clk);
        operand = 32'h0000_00F0; size = 2'd0; rotate = 1'b1; left = 1'b1;
        count = 8'd10; cc_in = 5'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        operand = 32'h1111_1111; count = 8'd1; left = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 200) begin @(negedge clk); lat++; end
        model(32'h0000_00F0, 2'd0, 1'b1, 1'b1, 8'd10, 1'b0, er, ec);
        chk("R10 busy start ignored", result, er);

        // sweep: sizes (R1), operations, directions, counts (R2 wraps above 63)
        for (int s = 0; s < 4; s++) begin
            for (int m = 0; m < 4; m++) begin
                for (int p = 0; p < 8; p++) begin
                    for (int ci = 0; ci < 17; ci++) begin
                        logic rot, lf, xi;
                        string tg;
                        rot = m[1]; lf = m[0]; xi = p[0] ^ ci[0];
                        run_op(pats[p], 2'(s), rot, lf, cnts[ci], xi, lat);
                        model(pats[p], 2'(s), rot, lf, cnts[ci], xi, er, ec);
                        if (cnts[ci][5:0] == 6'd0) tg = "R8";
                        else if (rot) tg = lf ? "R3" : "R4";
                        else tg = lf ? "R7" : "R6";
                        chk($sformatf("R2 latency cnt=%0d", cnts[ci]), 32'(lat),
                            32'(int'(cnts[ci][5:0]) + 1));
                        chk($sformatf("%s R1 result sz=%0d cnt=%0d op=%h", tg, s, cnts[ci], pats[p]),
                            result, er);
                        chk($sformatf("%s cc sz=%0d cnt=%0d op=%h", rot ? "R5" : tg, s, cnts[ci], pats[p]),
                            32'(cc_out), 32'(ec));
                        if (s < 2)
                            chk("R9 upper bits", result & (s == 0 ? 32'hFFFF_FF00 : 32'hFFFF_0000),
                                pats[p] & (s == 0 ? 32'hFFFF_FF00 : 32'hFFFF_0000));
                    end
                end
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule